// File: doc/BRIEF.md
# Bidirectional Funnel Shifter

A purely combinational N-bit shifter that produces logical, arithmetic and rotate shifts to the right or to the left from a single datapath. The operand is first widened into a 2N-1 bit staging word. The operand sits at one end of that word and the fill bits for the chosen kind of shift sit at the other. An N-bit window is then cut from the staging word by a chain of log2 N two-input multiplexer stages. Each stage is steered directly by one bit of a window offset, with no decoding.

For a right shift the offset is the shift amount itself. For a left shift the staging word is mirrored and the offset is the bitwise inverse of the amount, which equals N-1-k. No adder sits in the amount path. The block is used as an execution-unit shifter. WIDTH must be a power of two, and the amount is always below WIDTH.

Top module: `funnel_shifter`

## Requirements
- R1: With an amount of 0, res_o equals opnd_i for every mode and both directions.
- R2: Logical right (mode_i = 2'b00, dir_left_i = 0) gives opnd_i shifted right by amt_i, with zeros entering at the MSB end.
- R3: Logical left (mode_i = 2'b00, dir_left_i = 1) gives opnd_i shifted left by amt_i, with zeros entering at bit 0; bits moved past the MSB are lost.
- R4: Arithmetic right (mode_i = 2'b01, dir_left_i = 0) fills the vacated upper positions with copies of opnd_i[WIDTH-1].
- R5: Arithmetic left (mode_i = 2'b01, dir_left_i = 1) gives exactly the logical left result.
- R6: Rotate right (mode_i = 2'b10, dir_left_i = 0) feeds the bits leaving bit 0 back in at the MSB end: res_o[i] = opnd_i[(i+k) mod WIDTH].
- R7: Rotate left (mode_i = 2'b10, dir_left_i = 1) feeds the bits leaving the MSB back in at bit 0: res_o[i] = opnd_i[(i-k) mod WIDTH].
- R8: The unused mode code 2'b11 behaves as a logical shift in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | WIDTH | Operand to shift |
| amt_i | input | AMT_W | Shift amount k, 0 to WIDTH-1 |
| dir_left_i | input | 1 | 1 = shift toward the MSB, 0 = toward bit 0 |
| mode_i | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 logical |
| res_o | output | WIDTH | Shifted result |

## Verification
Two functions meet in every evaluation: the direction control mirrors the staging word, and it also inverts the amount into the window offset. A fault in either one alone still gives correct results for some amounts. For example, a left shift by 0 uses the highest offset and takes none of the fill bits, while a left shift by WIDTH-1 uses offset 0 and takes almost nothing but fill bits. For this reason every mode, both directions and every amount are applied together over all operand values. Each result is compared against a bit-by-bit reference built from the requirements, so a mismatch between the mirroring and the offset shows up at the amount where the window crosses into the fill bits.

// File: rtl/funnel_pkg.sv
package funnel_pkg;
  typedef enum logic [1:0] {
    SHF_LOGIC = 2'b00,
    SHF_ARITH = 2'b01,
    SHF_ROT   = 2'b10,
    SHF_RSVD  = 2'b11
  } shf_mode_e;
endpackage

// File: rtl/funnel_word_build.sv
module funnel_word_build
  import funnel_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned WW = 2 * WIDTH - 1
) (
  input  logic [WIDTH-1:0] opnd_i,
  input  logic             dir_left_i,
  input  shf_mode_e        mode_i,
  output logic [WW-1:0]    word_o
);
  logic [WIDTH-2:0] fill;

  always_comb begin
    fill = '0;
    if (dir_left_i) begin
      // left: only rotate brings bits back; arithmetic left equals logical
      if (mode_i == SHF_ROT) fill = opnd_i[WIDTH-1:1];
      word_o = {opnd_i, fill};
    end else begin
      unique case (mode_i)
        SHF_ROT:   fill = opnd_i[WIDTH-2:0];
        SHF_ARITH: fill = {(WIDTH-1){opnd_i[WIDTH-1]}};
        default:   fill = '0;
      endcase
      word_o = {fill, opnd_i};
    end
  end
endmodule

// File: rtl/funnel_amt_enc.sv
module funnel_amt_enc #(
  parameter int unsigned AMT_W = 3
) (
  input  logic [AMT_W-1:0] amt_i,
  input  logic             dir_left_i,
  output logic [AMT_W-1:0] off_o
);
  // ~k == N-1-k for power-of-two N: no subtractor needed
  assign off_o = dir_left_i ? ~amt_i : amt_i;
endmodule

// File: rtl/funnel_mux_stages.sv
module funnel_mux_stages #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned AMT_W = 3,
  localparam int unsigned WW = 2 * WIDTH - 1
) (
  input  logic [WW-1:0]    word_i,
  input  logic [AMT_W-1:0] off_i,
  output logic [WIDTH-1:0] win_o
);
  logic [WW-1:0] lvl;

  // one 2:1 mux rank per offset bit, rank s moves by 2**s
  always_comb begin
    lvl = word_i;
    for (int s = 0; s < AMT_W; s++) begin
      if (off_i[s]) lvl = lvl >> (1 << s);
    end
    win_o = lvl[WIDTH-1:0];
  end
endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter
  import funnel_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opnd_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             dir_left_i,
  input  logic [1:0]       mode_i,
  output logic [WIDTH-1:0] res_o
);
  localparam int unsigned WW = 2 * WIDTH - 1;

  logic [WW-1:0]    word;
  logic [AMT_W-1:0] off;

  funnel_word_build #(.WIDTH(WIDTH)) u_word (
    .opnd_i     (opnd_i),
    .dir_left_i (dir_left_i),
    .mode_i     (shf_mode_e'(mode_i)),
    .word_o     (word)
  );

  funnel_amt_enc #(.AMT_W(AMT_W)) u_enc (
    .amt_i      (amt_i),
    .dir_left_i (dir_left_i),
    .off_o      (off)
  );

  funnel_mux_stages #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_mux (
    .word_i (word),
    .off_i  (off),
    .win_o  (res_o)
  );
endmodule

// File: rtl/funnel_shifter_chk.sv
module funnel_shifter_chk #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned AMT_W = 3
) (
  input logic [WIDTH-1:0] opnd_i,
  input logic [AMT_W-1:0] amt_i,
  input logic             dir_left_i,
  input logic [1:0]       mode_i,
  input logic [WIDTH-1:0] res_o
);
  always_comb begin
    if (!$isunknown({opnd_i, amt_i, dir_left_i, mode_i})) begin
      if (amt_i == '0)
        a_r1_zero_amt: assert (res_o == opnd_i);
      if (!dir_left_i && mode_i[0] == mode_i[1] && amt_i != '0)
        a_r2_lsr_msb_zero: assert (res_o[WIDTH-1] == 1'b0);
      if (dir_left_i && mode_i != 2'b10 && amt_i != '0)
        a_r3_lsl_lsb_zero: assert (res_o[0] == 1'b0);
      if (!dir_left_i && mode_i == 2'b01)
        a_r4_sign_kept: assert (res_o[WIDTH-1] == opnd_i[WIDTH-1]);
      if (!dir_left_i && mode_i == 2'b10)
        a_r6_ror_ones: assert ($countones(res_o) == $countones(opnd_i));
      if (dir_left_i && mode_i == 2'b10)
        a_r7_rol_ones: assert ($countones(res_o) == $countones(opnd_i));
    end
  end
endmodule

bind funnel_shifter funnel_shifter_chk #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (
  .opnd_i     (opnd_i),
  .amt_i      (amt_i),
  .dir_left_i (dir_left_i),
  .mode_i     (mode_i),
  .res_o      (res_o)
);

// File: tb/funnel_shifter_test.sv
module funnel_shifter_test;
  localparam int W = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic [W-1:0]  opnd;
  logic [AW-1:0] amt;
  logic          left;
  logic [1:0]    mode;
  logic [W-1:0]  res;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  funnel_shifter #(.WIDTH(W)) uut (
    .opnd_i(opnd), .amt_i(amt), .dir_left_i(left), .mode_i(mode), .res_o(res)
  );

  // bitwise reference built from the requirement text
  function automatic logic [W-1:0] model(logic [W-1:0] a, int k, bit l, logic [1:0] m);
    logic [W-1:0] y;
    for (int i = 0; i < W; i++) begin
      int src;
      src = l ? i - k : i + k;
      if (src >= 0 && src < W) y[i] = a[src];
      else if (m == 2'b10) y[i] = a[(src + W) % W];
      else if (m == 2'b01 && !l) y[i] = a[W-1];
      else y[i] = 1'b0;
    end
    return y;
  endfunction

  task automatic apply(logic [W-1:0] a, int k, bit l, logic [1:0] m);
    @(negedge clk);
    opnd = a; amt = AW'(k); left = l; mode = m;
    #2;
  endtask

  task automatic chk(string req, logic [W-1:0] exp);
    n_chk++;
    if (res !== exp) begin
      n_err++;
      $display("FAIL %s opnd=%b k=%0d left=%0b mode=%b: got %b exp %b",
               req, opnd, amt, left, mode, res, exp);
    end
  endtask

  task automatic sweep(string req, bit l, logic [1:0] m);
    for (int k = 0; k < W; k++) begin
      for (int a = 0; a < (1 << W); a++) begin
        opnd = W'(a); amt = AW'(k); left = l; mode = m;
        #1;
        chk(req, model(W'(a), k, l, m));
      end
      @(negedge clk);
    end
  endtask

  task automatic t_idle;
    apply('0, 0, 1'b0, 2'b00);
    chk("R1 idle", 8'h00);
  endtask

  task automatic t_examples;
    // 8-bit form of the 4-bit worked cases, amount 1
    apply(8'b1000_1011, 1, 1'b0, 2'b00); chk("R2", 8'b0100_0101);
    apply(8'b1000_1011, 1, 1'b1, 2'b00); chk("R3", 8'b0001_0110);
    apply(8'b1000_1011, 1, 1'b0, 2'b01); chk("R4", 8'b1100_0101);
    apply(8'b1000_1011, 1, 1'b1, 2'b01); chk("R5", 8'b0001_0110);
    apply(8'b1000_1011, 1, 1'b0, 2'b10); chk("R6", 8'b1100_0101);
    apply(8'b1000_1011, 1, 1'b1, 2'b10); chk("R7", 8'b0001_0111);
    apply(8'b1000_0000, 7, 1'b0, 2'b01); chk("R4 max", 8'hFF);
    apply(8'b0000_0001, 7, 1'b1, 2'b10); chk("R7 max", 8'h80);
    apply(8'hA5, 0, 1'b1, 2'b11);        chk("R1 k0", 8'hA5);
  endtask

  task automatic t_zero_amt;
    for (int m = 0; m < 4; m++)
      for (int l = 0; l < 2; l++) begin
        apply(8'h96, 0, l[0], m[1:0]);
        chk("R1", 8'h96);
      end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    opnd = '0; amt = '0; left = 1'b0; mode = 2'b00;
    t_idle();
    t_examples();
    t_zero_amt();
    sweep("R2", 1'b0, 2'b00);
    sweep("R3", 1'b1, 2'b00);
    sweep("R4", 1'b0, 2'b01);
    sweep("R5", 1'b1, 2'b01);
    sweep("R6", 1'b0, 2'b10);
    sweep("R7", 1'b1, 2'b10);
    sweep("R8", 1'b0, 2'b11);
    sweep("R8", 1'b1, 2'b11);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule